// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block stores subroutine return addresses for a small 8-bit microcontroller core. Call and interrupt logic push a program address when a subroutine or handler is entered. A return instruction pops the stack and loads the top entry into the program counter. The stack has eight levels. Each level holds a 12-bit program address.

There is no stack pointer. The levels form a chain of registers that moves as a whole. A push moves every entry one level deeper and places the new address on top. The old bottom entry is dropped without notice. A pop moves every entry one level toward the top, and the bottom level keeps its own value. Once the stack has been popped empty, every further pop returns the bottom value again, so it never returns an undefined address. The block never reports overflow or underflow.

The top entry drives the output directly through wiring, with no register in between. The program counter can therefore take the return address in the same cycle that the pop strobe is high.

Top module: `rstack_top`

## Requirements
- R1: The stack holds exactly eight 12-bit entries. After nine pushes, eight pops return the last eight pushed addresses, newest first.
- R2: `tos_o` always equals the current level-1 entry. During a cycle in which `pop_i` is high, `tos_o` shows the address being returned.
- R3: A pop with no push loads each level n, for n = 1 to 7, with the value level n+1 held before the clock edge.
- R4: A pop with no push leaves level 8 unchanged, so levels 7 and 8 are then equal. Any number of further pops keeps returning the level-8 value.
- R5: A push loads level 1 with `push_addr_i` and each level n+1 with the value level n held before the edge. The old level-8 value is discarded without any flag.
- R6: When `push_i` and `pop_i` are high in the same cycle, the block performs only the push and ignores the pop.
- R7: While `rst_n` is low, all eight levels are cleared to zero.
- R8: In a cycle with neither strobe high, no level changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stack updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all levels |
| push_i | input | 1 | Push strobe |
| push_addr_i | input | 12 | Return address to push |
| pop_i | input | 1 | Pop strobe |
| tos_o | output | 12 | Top-of-stack address (level 1) |

## Verification
Only level 1 can be seen at the ports. A wrong value in a deeper level k therefore shows up on `tos_o` only after at least k-1 pops with no push in between. The bench runs long streams of pushes, pops, simultaneous strobes and idle cycles, and compares `tos_o` against an arithmetic model on every cycle. It also drains the full stack and keeps popping past the bottom, so that every level reaches the output and the bottom-retention rule is checked. The bound checker watches all levels directly. It flags a bad shift or a lost bottom value in the cycle right after the edge that caused it.

// File: rtl/rstack_pkg.sv
package rstack_pkg;
    localparam int unsigned DEF_DEPTH  = 8;
    localparam int unsigned DEF_ADDR_W = 12;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stack_op_e;
endpackage

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
    import rstack_pkg::*;
(
    input  logic      push_i,
    input  logic      pop_i,
    output stack_op_e op_o
);
    // push outranks pop (R6)
    always_comb begin
        if (push_i)     op_o = OP_PUSH;
        else if (pop_i) op_o = OP_POP;
        else            op_o = OP_HOLD;
    end
endmodule

// File: rtl/rstack_level.sv
module rstack_level
    import rstack_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  stack_op_e         op_i,
    input  logic [ADDR_W-1:0] cur_i,    // this level's present value
    input  logic [ADDR_W-1:0] upper_i,  // level above, or new address for level 1
    input  logic [ADDR_W-1:0] lower_i,  // level below, or itself for the bottom
    output logic [ADDR_W-1:0] next_o
);
    always_comb begin
        unique case (op_i)
            OP_PUSH: next_o = upper_i;
            OP_POP:  next_o = lower_i;
            default: next_o = cur_i;
        endcase
    end
endmodule

// File: rtl/rstack_top.sv
module rstack_top
    import rstack_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] tos_o
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] lvl;  // index 0 = level 1 (top)
    } state_t;

    state_t    st_d, st_q;
    stack_op_e op;
    logic [DEPTH-1:0][ADDR_W-1:0] cell_next;

    rstack_ctrl u_ctrl (
        .push_i (push_i),
        .pop_i  (pop_i),
        .op_o   (op)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        logic [ADDR_W-1:0] up_src, low_src;
        if (g == 0) begin : g_top
            assign up_src = push_addr_i;
        end else begin : g_mid
            assign up_src = st_q.lvl[g-1];
        end
        if (g == LAST) begin : g_bot
            assign low_src = st_q.lvl[g];   // bottom keeps its value on pop
        end else begin : g_above
            assign low_src = st_q.lvl[g+1];
        end
        rstack_level #(.ADDR_W(ADDR_W)) u_level (
            .op_i    (op),
            .cur_i   (st_q.lvl[g]),
            .upper_i (up_src),
            .lower_i (low_src),
            .next_o  (cell_next[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.lvl = cell_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tos_o = st_q.lvl[0];
endmodule

// File: rtl/rstack_chk.sv
module rstack_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         push_i,
    input logic                         pop_i,
    input logic [ADDR_W-1:0]            push_addr_i,
    input logic [ADDR_W-1:0]            tos_o,
    input logic [DEPTH-1:0][ADDR_W-1:0] lvl
);
    assert_push_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> tos_o == $past(push_addr_i));

    assert_push_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> lvl[DEPTH-1:1] == $past(lvl[DEPTH-2:0]));

    assert_pop_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> lvl[DEPTH-2:0] == $past(lvl[DEPTH-1:1]));

    assert_pop_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> ($stable(lvl[DEPTH-1]) && lvl[DEPTH-2] == lvl[DEPTH-1]));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !push_i) |=> $stable(lvl));

    assert_tos_level1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tos_o == lvl[0]);
endmodule

bind rstack_top rstack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .tos_o       (tos_o),
    .lvl         (st_q.lvl)
);

// File: tb/tb_rstack_top.sv
`timescale 1ns/1ps
module tb_rstack_top;
    localparam int DEPTH = 8;
    localparam int AW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic [AW-1:0] tos_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [AW-1:0] model [DEPTH];
    logic [15:0]   lfsr = 16'hACE1;

    always #5 clk = ~clk;

    rstack_top dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i),
        .push_addr_i(push_addr_i), .pop_i(pop_i), .tos_o(tos_o)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tos_o=%03h expected %03h at %0t", req, act, exp, $time);
        end
    endtask

    // Checks the result of the previous operation at the negedge, then applies a new one.
    task automatic do_op(input string req, input logic ps, input logic pp, input logic [AW-1:0] a);
        @(negedge clk);
        check(req, tos_o, model[0]);
        push_i = ps; pop_i = pp; push_addr_i = a;
        #1 check("R2 same-cycle top", tos_o, model[0]);
        @(posedge clk);
        if (ps) begin
            for (int i = DEPTH-1; i > 0; i--) model[i] = model[i-1];
            model[0] = a;
        end else if (pp) begin
            for (int i = 0; i < DEPTH-1; i++) model[i] = model[i+1];
        end
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        check(req, tos_o, model[0]);
        push_i = 0; pop_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; push_i = 0; pop_i = 0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R7: all levels zero after reset; pop through every level
        for (int i = 0; i < DEPTH + 2; i++) do_op("R7 reset zero", 0, 1, '0);

        // R1, R5: nine pushes, oldest lost; then drain
        for (int i = 1; i <= DEPTH + 1; i++) do_op("R5 push", 1, 0, AW'(12'h100 + i * 17));
        for (int i = 0; i < DEPTH; i++) do_op("R1 drain depth", 0, 1, '0);
        // R4: popping past bottom keeps returning level 8 (first pushed surviving = i=2)
        for (int i = 0; i < 12; i++) do_op("R4 bottom retained", 0, 1, '0);
        idle_check("R4 bottom value");
        check("R4 bottom value", tos_o, AW'(12'h100 + 2 * 17));

        // R6: simultaneous strobes push only
        do_op("R6 setup", 1, 0, 12'hABC);
        do_op("R6 push wins", 1, 1, 12'h5A5);
        do_op("R6 push wins", 0, 0, 12'h000);
        do_op("R6 after", 0, 1, '0);

        // R8: idle cycles with address toggling have no effect
        for (int i = 0; i < 10; i++) do_op("R8 idle hold", 0, 0, AW'(i * 301));

        // R3 etc: long pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            logic ps, pp;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ps = lfsr[0] & lfsr[3];
            pp = lfsr[1] | lfsr[5];
            if (ps && pp)       do_op("R6 random", ps, pp, lfsr[15:4]);
            else if (ps)        do_op("R5 random", ps, pp, lfsr[15:4]);
            else if (pp)        do_op("R3 random", ps, pp, lfsr[15:4]);
            else                do_op("R8 random", ps, pp, lfsr[15:4]);
        end

        // mid-run reset, R7 again
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_op("R7 second reset", 0, 1, '0);
        idle_check("R7 final");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule